// File: doc/BRIEF.md
# Data-Steered Multi-Sequencer Processing Array

This block holds a row of processing elements. Each element keeps a private copy of one shared program, one data word and one response flag. After a start pulse, every element fetches, decodes and executes its copy of the program at its own pace. Each element chooses its own route through the branches according to its own data. There is no broadcast instruction stream and no activity mask. An element that finishes stays idle while the others carry on. The whole run therefore lasts exactly as long as the longest route taken by any element.

A host loads the program through a single write port. Each write lands in the same slot of every element's program store. The host seeds each data word through a selected-element write, pulses `start`, and waits for `all_done`. It then reads each element's data word, response flag and executed-instruction count through a read selector. The instruction word has 16 bits: opcode in bits [15:12], immediate in bits [11:4], branch target in bits [3:0]. Each instruction takes one clock.

Top module: `mimd_ap_array`

## Requirements
- R1: After reset every done bit is 1, `all_done` is 1, and every element's data word, response flag and cycle count read back as 0.
- R2: A program write stores `prog_wdata` at `prog_addr` in every element's program store, and every element executes the same stored program. Fields: opcode [15:12], immediate [11:4], target [3:0].
- R3: Test opcodes write the response flag with the predicate result and discard the old flag: 0x1 data<imm, 0x2 data==imm, 0x3 data>imm, 0x4 (data AND imm)!=0.
- R4: Processing opcodes replace the element's data word: 0x5 load imm, 0x6 add imm modulo 256, 0x7 subtract imm modulo 256, 0x8 shift left by imm[2:0], 0x9 AND imm, 0xA OR imm, 0xB XOR imm.
- R5: Opcode 0xC always jumps to the target. Opcode 0xD jumps to the target when the response flag is 0 and otherwise goes to the next address.
- R6: Opcode 0x0 ends the element's run and sets its done bit. Finishing a non-jumping instruction at the last program address also ends the run. A done element's state stays frozen until the next start.
- R7: The clock edge that samples `start` clears every done bit, program counter and cycle count, and keeps data words and response flags. From the next edge on, each element executes one instruction per clock.
- R8: Each element's cycle count equals the number of instructions it executed since start, the ending instruction included. `all_done` rises exactly as many clocks after the start edge as the largest count.
- R9: A host data write to an element whose done bit is 0 is ignored. A write to a done element replaces its data word.
- R10: Opcodes 0xE and 0xF change nothing except advancing to the next address.
- R11: `all_done` is 1 exactly when every bit of `done_vec` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program write strobe (all elements) |
| prog_addr | input | 4 | Program slot to write |
| prog_wdata | input | 16 | Instruction word to write |
| start | input | 1 | Start pulse for all elements |
| data_we | input | 1 | Host data write strobe |
| data_sel | input | 2 | Element chosen for the data write |
| data_wdata | input | 8 | Data value to write |
| rd_sel | input | 2 | Element chosen for readback |
| rd_data | output | 8 | Data word of the selected element |
| rd_resp | output | 1 | Response flag of the selected element |
| rd_cycles | output | 16 | Executed-instruction count of the selected element |
| done_vec | output | 4 | Per-element done bits |
| all_done | output | 1 | All elements have finished |

## Verification
The bench runs programs in which elements take routes of clearly different lengths: early exit, taken and untaken conditional jumps, a counted loop, and running off the last address. A design that synchronised the elements, or counted cycles wrongly, would raise `all_done` at the wrong clock or report a wrong count. A test that ANDs into the old response flag instead of overwriting it gives a wrong flag for the element whose first test failed. A conditional jump sitting at the last address and not taken must end the run; a design that wraps the program counter to 0 would keep executing. A data write aimed at a running element must leave its final result unchanged.

// File: rtl/mimd_ap_pkg.sv
package mimd_ap_pkg;
    localparam int OPC_W   = 4;
    localparam int IMM_W   = 8;
    localparam int TGT_W   = 4;
    localparam int INSTR_W = OPC_W + IMM_W + TGT_W;

    typedef enum logic [OPC_W-1:0] {
        OP_EXIT = 4'h0,
        OP_TLT  = 4'h1,
        OP_TEQ  = 4'h2,
        OP_TGT  = 4'h3,
        OP_TANY = 4'h4,
        OP_LDI  = 4'h5,
        OP_ADD  = 4'h6,
        OP_SUB  = 4'h7,
        OP_SHL  = 4'h8,
        OP_AND  = 4'h9,
        OP_OR   = 4'hA,
        OP_XOR  = 4'hB,
        OP_JMP  = 4'hC,
        OP_JNR  = 4'hD,
        OP_RSV0 = 4'hE,
        OP_RSV1 = 4'hF
    } op_e;
endpackage

// File: rtl/mimd_ap_exec.sv
module mimd_ap_exec
    import mimd_ap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  a_cur,
    input  logic               r_cur,
    output logic [DATA_W-1:0]  a_nxt,
    output logic               r_nxt,
    output logic               is_exit,
    output logic               do_jump,
    output logic [TGT_W-1:0]   target
);
    op_e               op;
    logic [DATA_W-1:0] imm;

    always_comb begin
        op      = op_e'(instr[INSTR_W-1 -: OPC_W]);
        imm     = DATA_W'(instr[TGT_W +: IMM_W]);
        target  = instr[TGT_W-1:0];
        a_nxt   = a_cur;
        r_nxt   = r_cur;
        is_exit = 1'b0;
        do_jump = 1'b0;
        unique case (op)
            OP_EXIT: is_exit = 1'b1;
            OP_TLT:  r_nxt = (a_cur < imm);
            OP_TEQ:  r_nxt = (a_cur == imm);
            OP_TGT:  r_nxt = (a_cur > imm);
            OP_TANY: r_nxt = |(a_cur & imm);
            OP_LDI:  a_nxt = imm;
            OP_ADD:  a_nxt = a_cur + imm;
            OP_SUB:  a_nxt = a_cur - imm;
            OP_SHL:  a_nxt = a_cur << imm[2:0];
            OP_AND:  a_nxt = a_cur & imm;
            OP_OR:   a_nxt = a_cur | imm;
            OP_XOR:  a_nxt = a_cur ^ imm;
            OP_JMP:  do_jump = 1'b1;
            OP_JNR:  do_jump = ~r_cur;
            default: ;
        endcase
    end
endmodule

// File: rtl/mimd_ap_element.sv
module mimd_ap_element
    import mimd_ap_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int PROG_DEPTH = 16,
    parameter int CYC_W      = 16,
    localparam int PC_W      = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_wdata,
    input  logic               start,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               done,
    output logic [DATA_W-1:0]  a_out,
    output logic               r_out,
    output logic [CYC_W-1:0]   cyc_out
);
    localparam logic [PC_W-1:0] LAST_PC = PC_W'(PROG_DEPTH - 1);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] a;
        logic              r;
        logic              done;
        logic [CYC_W-1:0]  cyc;
    } elem_st_t;

    elem_st_t           st_d, st_q;
    logic [INSTR_W-1:0] mem_q [PROG_DEPTH];
    logic [INSTR_W-1:0] cur_instr;
    logic [DATA_W-1:0]  ex_a;
    logic               ex_r, ex_exit, ex_jump;
    logic [TGT_W-1:0]   ex_tgt;

    always_ff @(posedge clk) begin
        if (prog_we) mem_q[prog_addr] <= prog_wdata;
    end

    assign cur_instr = mem_q[st_q.pc];

    mimd_ap_exec #(.DATA_W(DATA_W)) exec_i (
        .instr   (cur_instr),
        .a_cur   (st_q.a),
        .r_cur   (st_q.r),
        .a_nxt   (ex_a),
        .r_nxt   (ex_r),
        .is_exit (ex_exit),
        .do_jump (ex_jump),
        .target  (ex_tgt)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.pc   = '0;
            st_d.done = 1'b0;
            st_d.cyc  = '0;
        end else if (!st_q.done) begin
            st_d.cyc = st_q.cyc + 1'b1;
            st_d.a   = ex_a;
            st_d.r   = ex_r;
            if (ex_exit) begin
                st_d.done = 1'b1;
            end else if (ex_jump) begin
                st_d.pc = PC_W'(ex_tgt);
            end else if (st_q.pc == LAST_PC) begin
                st_d.done = 1'b1;
            end else begin
                st_d.pc = st_q.pc + 1'b1;
            end
        end else if (wr_en) begin
            st_d.a = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.done <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign a_out   = st_q.a;
    assign r_out   = st_q.r;
    assign cyc_out = st_q.cyc;
endmodule

// File: rtl/mimd_ap_array.sv
module mimd_ap_array
    import mimd_ap_pkg::*;
#(
    parameter int NUM_PE     = 4,
    parameter int DATA_W     = 8,
    parameter int PROG_DEPTH = 16,
    parameter int CYC_W      = 16,
    localparam int PC_W      = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1,
    localparam int SEL_W     = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_wdata,
    input  logic               start,
    input  logic               data_we,
    input  logic [SEL_W-1:0]   data_sel,
    input  logic [DATA_W-1:0]  data_wdata,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_resp,
    output logic [CYC_W-1:0]   rd_cycles,
    output logic [NUM_PE-1:0]  done_vec,
    output logic               all_done
);
    logic [DATA_W-1:0] a_arr   [NUM_PE];
    logic              r_arr   [NUM_PE];
    logic [CYC_W-1:0]  cyc_arr [NUM_PE];

    for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
        logic sel_hit;
        assign sel_hit = data_we && (data_sel == SEL_W'(g));
        mimd_ap_element #(
            .DATA_W     (DATA_W),
            .PROG_DEPTH (PROG_DEPTH),
            .CYC_W      (CYC_W)
        ) pe_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .prog_we    (prog_we),
            .prog_addr  (prog_addr),
            .prog_wdata (prog_wdata),
            .start      (start),
            .wr_en      (sel_hit),
            .wr_data    (data_wdata),
            .done       (done_vec[g]),
            .a_out      (a_arr[g]),
            .r_out      (r_arr[g]),
            .cyc_out    (cyc_arr[g])
        );
    end

    always_comb begin
        rd_data   = '0;
        rd_resp   = 1'b0;
        rd_cycles = '0;
        for (int i = 0; i < NUM_PE; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data   = a_arr[i];
                rd_resp   = r_arr[i];
                rd_cycles = cyc_arr[i];
            end
        end
    end

    assign all_done = &done_vec;
endmodule

// File: rtl/mimd_ap_checker.sv
module mimd_ap_checker
    import mimd_ap_pkg::*;
#(
    parameter int NUM_PE     = 4,
    parameter int DATA_W     = 8,
    parameter int PROG_DEPTH = 16,
    parameter int CYC_W      = 16,
    localparam int PC_W      = (PROG_DEPTH > 1) ? $clog2(PROG_DEPTH) : 1,
    localparam int SEL_W     = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               prog_we,
    input logic [PC_W-1:0]    prog_addr,
    input logic [INSTR_W-1:0] prog_wdata,
    input logic               start,
    input logic               data_we,
    input logic [SEL_W-1:0]   data_sel,
    input logic [DATA_W-1:0]  data_wdata,
    input logic [SEL_W-1:0]   rd_sel,
    input logic [DATA_W-1:0]  rd_data,
    input logic               rd_resp,
    input logic [CYC_W-1:0]   rd_cycles,
    input logic [NUM_PE-1:0]  done_vec,
    input logic               all_done
);
    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (done_vec == '0)); // R7

    AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rd_cycles == '0) || (rd_sel != $past(rd_sel))); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ((done_vec & $past(done_vec)) == $past(done_vec))); // R6

    AST_FROZEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !data_we && done_vec[rd_sel])
        |=> (rd_sel != $past(rd_sel)) || ($stable(rd_data) && $stable(rd_resp) && $stable(rd_cycles))); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !done_vec[rd_sel])
        |=> (rd_sel != $past(rd_sel)) || (rd_cycles == CYC_W'($past(rd_cycles) + 1'b1))); // R8
endmodule

bind mimd_ap_array mimd_ap_checker #(
    .NUM_PE     (NUM_PE),
    .DATA_W     (DATA_W),
    .PROG_DEPTH (PROG_DEPTH),
    .CYC_W      (CYC_W)
) chk_i (.*);

// File: tb/mimd_ap_array_tb_top.sv
module mimd_ap_array_tb_top;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [3:0]  prog_addr = '0;
    logic [15:0] prog_wdata = '0;
    logic        start = 1'b0;
    logic        data_we = 1'b0;
    logic [1:0]  data_sel = '0;
    logic [7:0]  data_wdata = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        rd_resp;
    logic [15:0] rd_cycles;
    logic [N-1:0] done_vec;
    logic        all_done;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mimd_ap_array dut_i (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_wdata(prog_wdata), .start(start), .data_we(data_we),
        .data_sel(data_sel), .data_wdata(data_wdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .rd_resp(rd_resp), .rd_cycles(rd_cycles),
        .done_vec(done_vec), .all_done(all_done)
    );

    // behavioural reference model
    logic [15:0] mprog [16];
    logic [7:0]  ma [N];
    bit          mr [N];
    bit          mdone [N];
    int          mpc [N];
    int          mcyc [N];

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                ma[i] = 0; mr[i] = 0; mdone[i] = 1; mpc[i] = 0; mcyc[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (start) begin
                    mpc[i] = 0; mdone[i] = 0; mcyc[i] = 0;
                end else if (!mdone[i]) begin
                    int op, imm, tg;
                    bit jumped;
                    op = mprog[mpc[i]][15:12];
                    imm = mprog[mpc[i]][11:4];
                    tg = mprog[mpc[i]][3:0];
                    jumped = 0;
                    mcyc[i]++;
                    case (op)
                        0: mdone[i] = 1;
                        1: mr[i] = (ma[i] < imm);
                        2: mr[i] = (ma[i] == imm);
                        3: mr[i] = (ma[i] > imm);
                        4: mr[i] = ((ma[i] & imm) != 0);
                        5: ma[i] = imm[7:0];
                        6: ma[i] = 8'(ma[i] + imm);
                        7: ma[i] = 8'(ma[i] - imm);
                        8: ma[i] = 8'(ma[i] << (imm % 8));
                        9: ma[i] = ma[i] & imm[7:0];
                        10: ma[i] = ma[i] | imm[7:0];
                        11: ma[i] = ma[i] ^ imm[7:0];
                        12: jumped = 1;
                        13: jumped = !mr[i];
                        default: ;
                    endcase
                    if (!mdone[i]) begin
                        if (jumped) mpc[i] = tg;
                        else if (mpc[i] == 15) mdone[i] = 1;
                        else mpc[i]++;
                    end
                end else if (data_we && data_sel == 2'(i)) begin
                    ma[i] = data_wdata;
                end
            end
            if (prog_we) mprog[prog_addr] = prog_wdata;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit all;
            all = 1;
            for (int i = 0; i < N; i++) begin
                chk("R6 done bit", done_vec[i], mdone[i]);
                all = all & mdone[i];
            end
            chk("R11 all_done", all_done, all);
            chk("R4 data word", rd_data, ma[rd_sel]);
            chk("R3 response", rd_resp, mr[rd_sel]);
            chk("R8 cycle count", rd_cycles, mcyc[rd_sel]);
        end
    end

    function automatic logic [15:0] ins(int op, int imm, int tg);
        return {4'(op), 8'(imm), 4'(tg)};
    endfunction

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr_prog(int addr, logic [15:0] w);
        prog_we = 1; prog_addr = 4'(addr); prog_wdata = w;
        tick();
        prog_we = 0;
    endtask

    task automatic wr_data(int idx, int v);
        data_we = 1; data_sel = 2'(idx); data_wdata = 8'(v);
        tick();
        data_we = 0;
    endtask

    task automatic read_el(int idx);
        rd_sel = 2'(idx);
        @(negedge clk); #1;
    endtask

    // pulse start, then count clocks until all_done; returns that count
    task automatic run(output int k);
        start = 1;
        tick();
        start = 0;
        @(negedge clk); #1;
        chk("R7 done cleared by start", int'(done_vec), 0);
        k = 0;
        while (!all_done) begin
            rd_sel = rd_sel + 1'b1;
            @(negedge clk); #1;
            k++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k, mx;
        repeat (3) tick();
        rst_n = 1;
        @(negedge clk); #1;
        for (int i = 0; i < N; i++) begin
            read_el(i);
            chk("R1 reset data", rd_data, 0);
            chk("R1 reset resp", rd_resp, 0);
            chk("R1 reset count", rd_cycles, 0);
        end
        chk("R1 reset done", int'(done_vec), 15);
        chk("R1 reset all_done", all_done, 1);

        // program 1: branch-heavy, paths differ per element
        for (int a = 0; a < 16; a++) wr_prog(a, ins(0, 0, 0));
        wr_prog(0, ins(1, 3, 0));
        wr_prog(1, ins(13, 0, 4));
        wr_prog(2, ins(5, 0, 0));
        wr_prog(3, ins(0, 0, 0));
        wr_prog(4, ins(7, 1, 0));
        wr_prog(5, ins(2, 3, 0));
        wr_prog(6, ins(13, 0, 9));
        wr_prog(7, ins(6, 1, 0));
        wr_prog(8, ins(0, 0, 0));
        wr_prog(9, ins(8, 1, 0));
        wr_data(0, 1); wr_data(1, 3); wr_data(2, 4); wr_data(3, 9);
        run(k);
        chk("R8 longest path program 1", k, 7);
        read_el(0);
        chk("R2 R4 el0 data", rd_data, 0);
        chk("R3 el0 response", rd_resp, 1);
        chk("R6 el0 early exit count", rd_cycles, 4);
        read_el(1);
        chk("R5 el1 taken branches", rd_data, 4);
        read_el(3);
        chk("R5 el3 data", rd_data, 16);

        // program 2: counted loop, no-op, run off the end
        wr_prog(0, ins(3, 0, 0));
        wr_prog(1, ins(13, 0, 4));
        wr_prog(2, ins(7, 1, 0));
        wr_prog(3, ins(12, 0, 0));
        wr_prog(4, ins(11, 8'h55, 0));
        wr_prog(5, ins(4, 1, 0));
        wr_prog(6, ins(14, 8'hFF, 5));
        for (int a = 7; a < 16; a++) wr_prog(a, ins(10, 8'h80, 0));
        wr_data(0, 0); wr_data(1, 2); wr_data(2, 5); wr_data(3, 7);
        start = 1;
        tick();
        start = 0;
        repeat (5) tick();
        wr_data(3, 8'h11);
        mx = 0;
        while (!all_done) tick();
        @(negedge clk); #1;
        for (int i = 0; i < N; i++) begin
            read_el(i);
            chk("R10 R6 loop result", rd_data, 8'hD5);
            if (rd_cycles > mx) mx = rd_cycles;
        end
        chk("R8 longest count", mx, 42);
        read_el(3);
        chk("R9 write to running element ignored", rd_data, 8'hD5);
        wr_data(2, 8'h33);
        read_el(2);
        chk("R9 write to done element", rd_data, 8'h33);

        // program 3: overwrite test, untaken branch at last address
        wr_prog(0, ins(2, 8'hD5, 0));
        wr_prog(1, ins(1, 8'h40, 0));
        wr_prog(2, ins(12, 0, 15));
        wr_prog(3, ins(8, 1, 0));
        wr_prog(4, ins(9, 8'h0F, 0));
        wr_prog(5, ins(7, 8'h0B, 0));
        wr_prog(6, ins(0, 0, 0));
        wr_prog(15, ins(13, 0, 3));
        run(k);
        chk("R8 longest path program 3", k, 8);
        read_el(2);
        chk("R3 test overwrites old flag", rd_resp, 1);
        chk("R6 untaken branch at last address ends", rd_cycles, 4);
        chk("R7 data kept across start", rd_data, 8'h33);
        read_el(0);
        chk("R4 shift and mask and sub", rd_data, 8'hFF);
        chk("R5 jump to target count", rd_cycles, 8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule